// File: doc/BRIEF.md
# Digital Phase-Stepper Loop

This block closes a fully digital phase-locked loop around a transmit phase interpolator, using the interpolator as its controlled oscillator. Two single-cycle events come in. One marks each reference period, derived from the reference clock. The other is a feedback event derived from the transmit clock. A bang-bang phase detector decides once per reference period whether the feedback is early or late. A proportional-integral filter then turns those decisions into a rate of interpolator steps. The loop gains are set by shift amounts on input ports, so the loop bandwidth can be chosen digitally.

Each step moves the transmit phase by 1/32 of a unit interval. The phase has no end stop, so the step count is reported as increment and decrement pulses and as a 5-bit phase code that wraps. A steady stepping rate acts as a frequency offset of the transmitter, and the integrator therefore holds the frequency the loop has learned. The integrator saturates at a programmable limit, which bounds the stepping rate. A lock flag reports, once per window of comparisons, whether the early and late decisions balanced.

Top module: `dpll_stepper`

## Requirements
- R1: A reference period is the span from one `ref_evt` pulse to the next, with length P cycles, and the feedback offset k is the number of cycles from the opening `ref_evt` to the first `fb_evt`. At the closing `ref_evt`, the detector emits `pd_late` if 2k < P and `pd_early` otherwise. The chosen output is a single-cycle pulse in the cycle after the closing `ref_evt`.
- R2: No decision is emitted for a period in which no `fb_evt` came. No decision is emitted when `fb_evt` coincides with the closing `ref_evt`. No decision is emitted for the first `ref_evt` after reset.
- R3: Each decision adds a proportional kick of (2^12 >> `kp_shift`) / 2^12 steps, forward for late and backward for early. A `kp_shift` above 12 disables the kick.
- R4: Each decision changes the integrator by 2^12 >> `ki_shift`, up for late and down for early. Between decisions, the block emits integrator / 2^12 steps per clock on average.
- R5: The integrator never exceeds +`freq_lim` or falls below -`freq_lim`, with `freq_lim` at most 4096. Decisions that would push it beyond the limit leave it at the limit.
- R6: At most one step is emitted per clock. `step_inc` and `step_dec` are never high together.
- R7: `phase_code` is 5 bits wide. It rises by one in the cycle after each `step_inc` and falls by one in the cycle after each `step_dec`, wrapping modulo 32.
- R8: Every 8 comparisons (`ref_evt` pulses), `locked` is set to 1 when the early and late counts in that window differ by at most 2, and cleared otherwise. It changes at no other time.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_evt | input | 1 | Reference period marker, one-cycle pulse |
| fb_evt | input | 1 | Feedback event from the transmit clock, one-cycle pulse |
| kp_shift | input | 5 | Proportional gain as a right shift of one step |
| ki_shift | input | 5 | Integral gain as a right shift of one step |
| freq_lim | input | 13 | Integrator magnitude limit, 1/4096 steps per clock |
| pd_early | output | 1 | Detector decision: feedback early |
| pd_late | output | 1 | Detector decision: feedback late |
| step_inc | output | 1 | Step the phase forward by 1/32 UI |
| step_dec | output | 1 | Step the phase backward by 1/32 UI |
| phase_code | output | 5 | Wrapping interpolator phase code |
| locked | output | 1 | Early and late decisions balanced over the last window |

## Verification
The assertions assume that `ref_evt` and `fb_evt` are one-cycle pulses and that `freq_lim` never exceeds 4096. The integrator bound is checked against the limit applied in the previous cycle, so it also holds when the limit is changed during operation. The bench drives both events as one-cycle pulses inside periods of fixed or random length. It draws the gains and the limit only within those ranges. In the random phase, the feedback offset follows the phase code, which closes the loop as an interpolator would.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_EARLY = 2'd1,
    PD_LATE  = 2'd2
  } pd_e;
endpackage

// File: rtl/bb_phase_det.sv
module bb_phase_det #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic pd_valid,
  output logic pd_early,
  output logic pd_late
);
  import dpll_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fb_pos;
  logic             seen;
  logic             armed;
  pd_e              dec;

  // the decision for the period that the current reference pulse closes
  always_comb begin
    dec = PD_NONE;
    if (ref_evt && armed && seen && !fb_evt) begin
      if ({fb_pos, 1'b0} < ({1'b0, cnt} + 1'b1)) dec = PD_LATE;
      else                                       dec = PD_EARLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      fb_pos   <= '0;
      seen     <= 1'b0;
      armed    <= 1'b0;
      pd_valid <= 1'b0;
      pd_early <= 1'b0;
      pd_late  <= 1'b0;
    end else begin
      pd_valid <= ref_evt;
      pd_early <= (dec == PD_EARLY);
      pd_late  <= (dec == PD_LATE);
      if (ref_evt) begin
        cnt   <= '0;
        seen  <= 1'b0;
        armed <= 1'b1;
      end else begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (fb_evt && !seen) begin
          seen   <= 1'b1;
          fb_pos <= cnt + 1'b1;
        end
      end
    end
  end

  // R1 R2
  pd_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_early || pd_late) |-> ($past(ref_evt) && !$past(fb_evt)));
  // R1
  pd_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pd_early, pd_late}));
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter #(
  parameter int FRAC_W = 12,
  parameter int SH_W   = 5,
  localparam int IW    = FRAC_W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pd_early,
  input  logic                 pd_late,
  input  logic [SH_W-1:0]      kp_shift,
  input  logic [SH_W-1:0]      ki_shift,
  input  logic [FRAC_W:0]      freq_lim,
  output logic signed [IW-1:0] integ,
  output logic signed [IW-1:0] kick
);
  localparam logic [IW-1:0] ONE_V = {{(IW-1){1'b0}}, 1'b1} << FRAC_W;

  logic [IW-1:0]        kp_mag, ki_mag;
  logic signed [IW-1:0] lim_p, lim_n, delta, sum, nxt;

  assign kp_mag = ONE_V >> kp_shift;
  assign ki_mag = ONE_V >> ki_shift;
  assign lim_p  = signed'({2'b00, freq_lim});
  assign lim_n  = -lim_p;

  always_comb begin
    delta = '0;
    if (pd_late)       delta = signed'(ki_mag);
    else if (pd_early) delta = -signed'(ki_mag);
    sum = integ + delta;
    if (sum > lim_p)      nxt = lim_p;
    else if (sum < lim_n) nxt = lim_n;
    else                  nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      kick  <= '0;
    end else begin
      integ <= nxt;
      if (pd_late)       kick <= signed'(kp_mag);
      else if (pd_early) kick <= -signed'(kp_mag);
      else               kick <= '0;
    end
  end

  // R5
  integ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (integ <= signed'({2'b00, $past(freq_lim)})) &&
    (integ >= -signed'({2'b00, $past(freq_lim)})));
endmodule

// File: rtl/step_nco.sv
module step_nco #(
  parameter int FRAC_W = 12,
  parameter int PH_W   = 5,
  localparam int IW    = FRAC_W + 3,
  localparam int AW    = FRAC_W + 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] integ,
  input  logic signed [IW-1:0] kick,
  output logic                 step_inc,
  output logic                 step_dec,
  output logic [PH_W-1:0]      phase_code
);
  localparam logic signed [AW-1:0] ONE_A = AW'(1) <<< FRAC_W;
  localparam logic signed [AW-1:0] CAP_A = AW'(4) <<< FRAC_W;

  logic signed [AW-1:0] acc, sum, nxt;
  logic                 inc_n, dec_n;

  always_comb begin
    sum   = acc + {{(AW-IW){integ[IW-1]}}, integ} + {{(AW-IW){kick[IW-1]}}, kick};
    inc_n = 1'b0;
    dec_n = 1'b0;
    nxt   = sum;
    if (sum >= ONE_A) begin
      inc_n = 1'b1;
      nxt   = sum - ONE_A;
    end else if (sum <= -ONE_A) begin
      dec_n = 1'b1;
      nxt   = sum + ONE_A;
    end
    if (nxt > CAP_A)       nxt = CAP_A;
    else if (nxt < -CAP_A) nxt = -CAP_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      step_inc   <= 1'b0;
      step_dec   <= 1'b0;
      phase_code <= '0;
    end else begin
      acc      <= nxt;
      step_inc <= inc_n;
      step_dec <= dec_n;
      if (step_inc)      phase_code <= phase_code + 1'b1;
      else if (step_dec) phase_code <= phase_code - 1'b1;
    end
  end

  // R6
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_inc && step_dec));
  // R7
  code_up_chk: assert property (@(posedge clk) disable iff (rst)
    step_inc |=> (phase_code == PH_W'($past(phase_code) + 1'b1)));
  // R7
  code_down_chk: assert property (@(posedge clk) disable iff (rst)
    step_dec |=> (phase_code == PH_W'($past(phase_code) - 1'b1)));
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_inc && !step_dec) |=> $stable(phase_code));
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int WIN_N    = 8,
  parameter int LOCK_TOL = 2,
  localparam int CW      = $clog2(WIN_N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_valid,
  input  logic pd_early,
  input  logic pd_late,
  output logic locked
);
  logic [CW-1:0] n_cnt, e_cnt, l_cnt, e_tot, l_tot, diff;
  logic          win_end;

  assign e_tot   = e_cnt + CW'(pd_early);
  assign l_tot   = l_cnt + CW'(pd_late);
  assign diff    = (e_tot > l_tot) ? (e_tot - l_tot) : (l_tot - e_tot);
  assign win_end = pd_valid && (n_cnt == CW'(WIN_N - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cnt  <= '0;
      e_cnt  <= '0;
      l_cnt  <= '0;
      locked <= 1'b0;
    end else if (pd_valid) begin
      if (win_end) begin
        n_cnt  <= '0;
        e_cnt  <= '0;
        l_cnt  <= '0;
        locked <= (diff <= CW'(LOCK_TOL));
      end else begin
        n_cnt <= n_cnt + 1'b1;
        e_cnt <= e_tot;
        l_cnt <= l_tot;
      end
    end
  end

  // R8
  lock_window_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(locked) |-> $past(win_end));
endmodule

// File: rtl/dpll_stepper.sv
module dpll_stepper #(
  parameter int FRAC_W   = 12,
  parameter int SH_W     = 5,
  parameter int CNT_W    = 8,
  parameter int PH_W     = 5,
  parameter int WIN_N    = 8,
  parameter int LOCK_TOL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_evt,
  input  logic              fb_evt,
  input  logic [SH_W-1:0]   kp_shift,
  input  logic [SH_W-1:0]   ki_shift,
  input  logic [FRAC_W:0]   freq_lim,
  output logic              pd_early,
  output logic              pd_late,
  output logic              step_inc,
  output logic              step_dec,
  output logic [PH_W-1:0]   phase_code,
  output logic              locked
);
  localparam int IW = FRAC_W + 3;

  logic                 pd_valid;
  logic signed [IW-1:0] integ, kick;

  bb_phase_det #(.CNT_W(CNT_W)) u_pd (
    .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .pd_valid(pd_valid), .pd_early(pd_early), .pd_late(pd_late)
  );

  pi_loop_filter #(.FRAC_W(FRAC_W), .SH_W(SH_W)) u_lf (
    .clk(clk), .rst(rst), .pd_early(pd_early), .pd_late(pd_late),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .freq_lim(freq_lim),
    .integ(integ), .kick(kick)
  );

  step_nco #(.FRAC_W(FRAC_W), .PH_W(PH_W)) u_nco (
    .clk(clk), .rst(rst), .integ(integ), .kick(kick),
    .step_inc(step_inc), .step_dec(step_dec), .phase_code(phase_code)
  );

  lock_det #(.WIN_N(WIN_N), .LOCK_TOL(LOCK_TOL)) u_lock (
    .clk(clk), .rst(rst), .pd_valid(pd_valid),
    .pd_early(pd_early), .pd_late(pd_late), .locked(locked)
  );
endmodule

// File: tb/dpll_stepper_tb.sv
`timescale 1ns/1ps
module dpll_stepper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_evt = 1'b0, fb_evt = 1'b0;
  logic [4:0]  kp_shift = 5'd31, ki_shift = 5'd31;
  logic [12:0] freq_lim = 13'd0;
  logic        pd_early, pd_late, step_inc, step_dec, locked;
  logic [4:0]  phase_code;

  int n_pass = 0, n_chk = 0;
  int n_inc = 0, n_dec = 0, n_early = 0, n_late = 0, n_both = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpll_stepper u_dut (
    .clk(clk), .rst(rst), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .freq_lim(freq_lim),
    .pd_early(pd_early), .pd_late(pd_late), .step_inc(step_inc),
    .step_dec(step_dec), .phase_code(phase_code), .locked(locked)
  );

  always @(negedge clk) if (!rst) begin
    n_inc   += int'(step_inc);
    n_dec   += int'(step_dec);
    n_early += int'(pd_early);
    n_late  += int'(pd_late);
    if (step_inc && step_dec) n_both++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  function automatic int exp_code(int inc, int dec);
    return (inc - dec) & 31;
  endfunction

  function automatic bit near(int a, int b);
    return (a >= b - 1) && (a <= b + 1);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_evt = 1'b0;
      fb_evt  = 1'b0;
    end
  endtask

  // one reference period of len cycles; off < 0 means no feedback event
  task automatic period(int len, int off);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ref_evt = (i == 0);
      fb_evt  = (i == off);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_evt = 1'b0; fb_evt = 1'b0;
    idle(3);
    rst = 1'b0;
    n_inc = 0; n_dec = 0; n_early = 0; n_late = 0; n_both = 0;
  endtask

  task automatic rate_test(string req, int exp_inc, int exp_dec);
    int i0, d0;
    idle(30);
    i0 = n_inc; d0 = n_dec;
    idle(400);
    chk(near(n_inc - i0, exp_inc), req, n_inc - i0, exp_inc);
    chk(near(n_dec - d0, exp_dec), req, n_dec - d0, exp_dec);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    // R9 reset state
    idle(4);
    chk({pd_early, pd_late, step_inc, step_dec, locked} == 5'b0, "R9 flags", 0, 0);
    chk(phase_code == 5'd0, "R9 phase_code", int'(phase_code), 0);
    rst = 1'b0;

    // R1 R2 detector decisions, gains off
    do_reset();
    kp_shift = 5'd31; ki_shift = 5'd31; freq_lim = 13'd4096;
    period(16, 3); period(16, 12); period(16, -1); period(16, 0); period(16, -1);
    idle(10);
    chk(n_late == 1, "R1 late count", n_late, 1);
    chk(n_early == 1, "R1 early count", n_early, 1);
    chk(n_inc + n_dec == 0, "R3 no steps with gains disabled", n_inc + n_dec, 0);

    // R3 full proportional kick, R7 wrap
    do_reset();
    kp_shift = 5'd0;
    for (int i = 0; i < 11; i++) period(16, 3);
    idle(10);
    chk(n_inc == 10, "R3 one step per late", n_inc, 10);
    chk(phase_code == 5'd10, "R7 phase_code", int'(phase_code), 10);
    for (int i = 0; i < 40; i++) period(16, 3);
    idle(10);
    chk(phase_code == 5'(exp_code(n_inc, n_dec)), "R7 wrap", int'(phase_code), exp_code(n_inc, n_dec));
    for (int i = 0; i < 8; i++) period(16, 12);
    idle(10);
    chk(n_dec == n_early && n_early > 0, "R3 step back per early", n_dec, n_early);
    chk(phase_code == 5'(exp_code(n_inc, n_dec)), "R7 after decrements", int'(phase_code), exp_code(n_inc, n_dec));

    // R3 half kick
    do_reset();
    kp_shift = 5'd1;
    for (int i = 0; i < 11; i++) period(16, 3);
    idle(10);
    chk(n_inc == 5, "R3 half kick", n_inc, 5);

    // R4 integral rate without saturation: two lates of 512 -> 1/4 step per clock
    do_reset();
    kp_shift = 5'd31; ki_shift = 5'd3; freq_lim = 13'd4096;
    for (int i = 0; i < 3; i++) period(16, 3);
    rate_test("R4 integral rate", 100, 0);

    // R5 saturation: three lates of 1024 held at 1024
    do_reset();
    ki_shift = 5'd2; freq_lim = 13'd1024;
    for (int i = 0; i < 4; i++) period(16, 3);
    rate_test("R5 positive limit", 100, 0);
    do_reset();
    for (int i = 0; i < 4; i++) period(16, 12);
    rate_test("R5 negative limit", 0, 100);

    // R8 lock window
    do_reset();
    kp_shift = 5'd31; ki_shift = 5'd31;
    for (int i = 0; i < 17; i++) period(16, (i % 2 == 0) ? 3 : 12);
    idle(5);
    chk(locked == 1'b1, "R8 balanced window", int'(locked), 1);
    for (int i = 0; i < 17; i++) period(16, 3);
    idle(5);
    chk(locked == 1'b0, "R8 one-sided window", int'(locked), 0);

    // R6 R7 random closed loop: interpolator model shifts feedback by the phase code
    do_reset();
    void'($urandom(32'd1234));
    kp_shift = 5'($urandom_range(0, 3));
    ki_shift = 5'($urandom_range(3, 8));
    freq_lim = 13'($urandom_range(256, 4096));
    base = 8;
    for (int i = 0; i < 400; i++) begin
      int len, off;
      len = $urandom_range(12, 24);
      base += $urandom_range(0, 2) - 1;
      off = (base - int'(phase_code) + 64) % len;
      if ($urandom_range(0, 9) == 0) off = -1;
      period(len, off);
    end
    idle(10);
    chk(n_both == 0, "R6 never both directions", n_both, 0);
    chk(phase_code == 5'(exp_code(n_inc, n_dec)), "R7 random tracking", int'(phase_code), exp_code(n_inc, n_dec));
    chk(n_inc + n_dec > 0, "R4 random loop steps", n_inc + n_dec, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule